// File: doc/BRIEF.md
# Pulse-Position Downlink Demodulator with Uplink Short Timer

This block recovers downlink bits from an envelope-detected on-off-keyed pulse stream, sampled by the tag's local clock. Every symbol is marked by three short pulses. The block counts local clock cycles over two intervals. The first runs from the rising edge of pulse one to that of pulse two. The second runs from pulse two to pulse three. The decision rests only on which interval is longer, so the bit is correct whatever the exact ratio between the reader and tag clocks. In the intended use the downlink runs at 125 kbit/s with pulses of about 12.5 % duty. Before the downlink starts, the tag sends a clock-recovery message so that the reader can match its bit period to the tag's clock.

The same block holds the uplink side, which uses load-shift keying. At the start of each uplink bit slot, a high bit shorts the resonant tank for a programmable number of clock cycles. Half a microsecond is the intended setting. A low bit leaves the tank alone.

The demodulator state machine has three states. In `DM_HUNT` it waits for pulse one, and an edge moves it to `DM_GAP1`. In `DM_GAP1` it counts, and an edge stores the first interval and moves it to `DM_GAP2`. In `DM_GAP2` it counts, and an edge makes the decision and returns it to `DM_HUNT`. From either gap state, a count that reaches the timeout with no edge also returns it to `DM_HUNT`. The uplink timer has two states. `UL_IDLE` goes to `UL_SHORT` when a slot opens with a high bit and a non-zero length. `UL_SHORT` goes back to `UL_IDLE` when the count runs out or a slot opens with a low bit. A slot that opens with a high bit while in `UL_SHORT` reloads the count and stays in `UL_SHORT`.

Top module: `ppm_link_top`

## Requirements
- R1: While reset is held, rx_valid, rx_bit and tx_short are all 0.
- R2: A symbol whose first interval, measured in local clocks between the rising edges of pulses one and two, is longer than the second interval (pulses two to three) gives rx_bit = 1.
- R3: A symbol whose first interval is shorter than or equal to the second gives rx_bit = 0. A tie decodes as 0.
- R4: Each complete three-pulse symbol gives exactly one rx_valid pulse, one cycle wide. rx_bit keeps its value until the next rx_valid.
- R5: The timeout is TMO = 2*MAX_IVL clocks (40 at defaults). An interval of exactly TMO clocks is accepted. When an edge and the timeout fall in the same cycle, the edge wins.
- R6: If the next pulse does not arrive within TMO clocks, the partial symbol is dropped with no rx_valid. The late pulse then counts as pulse one of a new symbol.
- R7: Only rising edges of rx_env count as pulses. A high level held for many cycles is one pulse.
- R8: When tx_slot is 1 and tx_bit is 1, tx_short goes high in the following cycle and stays high for exactly short_len cycles.
- R9: A slot with tx_bit = 0, or with short_len = 0, leaves tx_short at 0.
- R10: A slot that opens while tx_short is high either reloads the count to short_len (tx_bit = 1) or ends the short in the next cycle (tx_bit = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local tag clock |
| rst_n | input | 1 | Active-low reset |
| rx_env | input | 1 | Envelope-detected downlink pulse level (asynchronous) |
| rx_bit | output | 1 | Last decoded downlink bit |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_bit |
| tx_slot | input | 1 | One-cycle strobe that opens an uplink bit slot |
| tx_bit | input | 1 | Uplink bit value, sampled with tx_slot |
| short_len | input | LW | Length of the tank short, in clocks |
| tx_short | output | 1 | Tank short enable |

## Verification
Two pairs of events can land in the same cycle. In the demodulator, a pulse edge can arrive in the very cycle the interval count reaches the timeout. The bench sweeps intervals up to exactly TMO and expects those symbols to decode rather than be dropped. In the uplink timer, a new slot strobe can arrive while a short is still running. The bench opens a second slot three cycles into a short and counts the total cycles tx_short is high: nine with a high bit, three with a low bit.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
    typedef enum logic [1:0] {
        DM_HUNT = 2'd0,
        DM_GAP1 = 2'd1,
        DM_GAP2 = 2'd2
    } dm_state_t;

    typedef enum logic {
        UL_IDLE  = 1'b0,
        UL_SHORT = 1'b1
    } ul_state_t;
endpackage

// File: rtl/ppm_edge.sv
module ppm_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic [SYNC:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[SYNC-1:0], level_in};
    end

    assign rise = pipe[SYNC-1] & ~pipe[SYNC];

    // R7
    one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ppm_demod.sv
module ppm_demod
    import ppm_pkg::*;
#(
    parameter int MAX_IVL = 20,
    localparam int TMO    = 2 * MAX_IVL,
    localparam int CW     = $clog2(TMO + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_in,
    output logic bit_out,
    output logic valid_out
);
    dm_state_t st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] first_ivl;
    logic          expired;

    assign expired = (cnt >= CW'(TMO));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= DM_HUNT;
        end else begin
            unique case (st)
                DM_HUNT: if (edge_in) st <= DM_GAP1;
                DM_GAP1: begin
                    if (edge_in)      st <= DM_GAP2;
                    else if (expired) st <= DM_HUNT;
                end
                DM_GAP2: begin
                    if (edge_in)      st <= DM_HUNT;
                    else if (expired) st <= DM_HUNT;
                end
                default: st <= DM_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            first_ivl <= '0;
        end else begin
            if (st == DM_HUNT || edge_in) cnt <= CW'(1);
            else                          cnt <= cnt + CW'(1);
            if (st == DM_GAP1 && edge_in) first_ivl <= cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            bit_out   <= 1'b0;
        end else begin
            valid_out <= (st == DM_GAP2) && edge_in;
            if (st == DM_GAP2 && edge_in) bit_out <= (first_ivl > cnt);
        end
    end

    // R5
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != DM_HUNT) |-> (cnt <= CW'(TMO)));
    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |=> !valid_out);
    // R4
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> $stable(bit_out));
endmodule

// File: rtl/ppm_ul_short.sv
module ppm_ul_short
    import ppm_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot,
    input  logic          bit_in,
    input  logic [LW-1:0] len,
    output logic          short_out
);
    ul_state_t     st;
    logic [LW-1:0] left;
    logic          fire;

    assign fire = slot && bit_in && (len != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= UL_IDLE;
            left <= '0;
        end else begin
            unique case (st)
                UL_IDLE: begin
                    if (fire) begin
                        st   <= UL_SHORT;
                        left <= len - LW'(1);
                    end
                end
                UL_SHORT: begin
                    if (fire) begin
                        left <= len - LW'(1);
                    end else if (slot || left == '0) begin
                        st <= UL_IDLE;
                    end else begin
                        left <= left - LW'(1);
                    end
                end
                default: st <= UL_IDLE;
            endcase
        end
    end

    always_comb short_out = (st == UL_SHORT);

    // R8
    short_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_out) |-> $past(slot && bit_in));
    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && bit_in && len == '0) |=> !short_out);
    // R10
    short_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(short_out) |-> ($past(slot) || $past(left == '0)));
endmodule

// File: rtl/ppm_link_top.sv
module ppm_link_top #(
    parameter int MAX_IVL = 20,
    parameter int LW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_env,
    output logic          rx_bit,
    output logic          rx_valid,
    input  logic          tx_slot,
    input  logic          tx_bit,
    input  logic [LW-1:0] short_len,
    output logic          tx_short
);
    logic rx_rise;

    ppm_edge #(.SYNC(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (rx_env),
        .rise     (rx_rise)
    );

    ppm_demod #(.MAX_IVL(MAX_IVL)) u_demod (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_in   (rx_rise),
        .bit_out   (rx_bit),
        .valid_out (rx_valid)
    );

    ppm_ul_short #(.LW(LW)) u_ul (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (tx_slot),
        .bit_in    (tx_bit),
        .len       (short_len),
        .short_out (tx_short)
    );
endmodule

// File: tb/sim_ppm_link_top.sv
`timescale 1ns/1ps
module sim_ppm_link_top;
    localparam int MAX_IVL = 20;
    localparam int TMO     = 2 * MAX_IVL;
    localparam int LW      = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_env = 1'b0;
    logic          rx_bit, rx_valid, tx_short;
    logic          tx_slot = 1'b0, tx_bit = 1'b0;
    logic [LW-1:0] short_len = '0;

    int checks = 0;
    int errors = 0;
    int nval = 0;
    logic last_bit = 1'b0;
    logic prev_valid = 1'b0;
    int wide_valid = 0;

    always #2 clk = ~clk;

    ppm_link_top #(.MAX_IVL(MAX_IVL), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_env(rx_env), .rx_bit(rx_bit),
        .rx_valid(rx_valid), .tx_slot(tx_slot), .tx_bit(tx_bit),
        .short_len(short_len), .tx_short(tx_short)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            nval++;
            last_bit = rx_bit;
            if (prev_valid) wide_valid++;
        end
        prev_valid = rx_valid;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int w);
        rx_env = 1'b1;
        idle(w);
        rx_env = 1'b0;
    endtask

    task automatic send_sym(input int d1, input int d2, input int w);
        pulse(w); idle(d1 - w);
        pulse(w); idle(d2 - w);
        pulse(w); idle(10);
    endtask

    task automatic sym_check(input int d1, input int d2, input int w, input string tag);
        int base;
        base = nval;
        send_sym(d1, d2, w);
        chk(nval == base + 1, {tag, " R4 valid count"}, nval - base, 1);
        chk(last_bit == (d1 > d2), tag, last_bit, int'(d1 > d2));
    endtask

    task automatic ul_run(input bit b, input int len, input int window, output int hi, output bit first);
        tx_bit = b; short_len = LW'(len); tx_slot = 1'b1;
        @(negedge clk);
        tx_slot = 1'b0;
        first = tx_short;
        hi = int'(tx_short);
        for (int i = 0; i < window; i++) begin
            @(negedge clk);
            hi += int'(tx_short);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi;
        bit first;
        int base;
        idle(3);
        // R1 reset values
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(rx_bit == 1'b0, "R1 rx_bit", rx_bit, 0);
        chk(tx_short == 1'b0, "R1 tx_short", tx_short, 0);
        rst_n = 1'b1;
        idle(3);

        // R2 / R3: interval sweep, ties included, up to TMO (R5)
        for (int a = 4; a <= TMO; a += 4)
            for (int b = 4; b <= TMO; b += 4)
                sym_check(a, b, 2, (a > b) ? "R2" : "R3");

        // R5: edge exactly at the timeout count wins
        sym_check(TMO, 5, 2, "R5 accept at TMO");
        sym_check(6, TMO, 2, "R5 accept at TMO second gap");

        // R6: late second pulse restarts the symbol
        base = nval;
        pulse(2); idle(TMO + 5 - 2);
        pulse(2); idle(6);
        pulse(2); idle(10);
        pulse(2); idle(12);
        chk(nval == base + 1, "R6 valid count", nval - base, 1);
        chk(last_bit == 1'b0, "R6 bit", last_bit, 0);
        sym_check(9, 5, 2, "R6 recovery");

        // R7: long high levels are single pulses
        sym_check(20, 14, 10, "R7 long pulse");
        sym_check(12, 30, 11, "R7 long pulse");
        chk(wide_valid == 0, "R4 valid width", wide_valid, 0);

        // R8 / R9 uplink sweep
        for (int len = 0; len <= 12; len++) begin
            for (int b = 0; b <= 1; b++) begin
                ul_run(b[0], len, len + 4, hi, first);
                chk(hi == (b ? len : 0), (b && len > 0) ? "R8 short length" : "R9 no short", hi, b ? len : 0);
                chk(first == (b && len > 0), (b && len > 0) ? "R8 start" : "R9 start", first, int'(b && len > 0));
            end
        end

        // R10: slot during a short, reload then cut
        for (int b = 0; b <= 1; b++) begin
            int total;
            ul_run(1'b1, 6, 2, hi, first);
            total = hi;
            ul_run(b[0], 6, 10, hi, first);
            total += hi;
            chk(total == (b ? 9 : 3), "R10 restart", total, b ? 9 : 3);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule